// File: doc/BRIEF.md
# Serial Port Register Controller

This block is the byte-wide register file that a small CPU uses to run a serial port. It sits between a single-byte CPU bus and two byte streams: received characters arrive on a valid/ready input, and transmitted characters leave on a one-cycle strobe. It holds a one-byte receive holding buffer behind the data register, three control/status registers, two baud-rate registers and three level interrupt lines: receive done, transmit done and transmit-data empty.

A received byte is masked to the configured character size when the CPU reads it. The CPU may set that size to 5, 6, 7 or 8 bits, and the nine-bit code is treated as 8 bits. Status and control writes pass through fixed write masks. The transmit-done flag is cleared by writing one to it. Each control write recomputes all three interrupt lines from the enables and the flags. Bit timing, baud generation and parity are handled elsewhere.

A power-down input holds the whole block in its reset state and makes the bus inert. Read data is registered and appears in the cycle after the access.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the registers read as follows: status (offset 1) 0x20, control (offset 2) 0x00, format (offset 3) 0x06, baud low (offset 4) 0x00, baud high (offset 5) 0x00. All three interrupt lines are low and rx_ready is low.
- R2: rx_ready is high only when the receive enable (control bit 4) is set, the holding buffer is empty and pwr_down is low. An accepted byte is held, and it sets the receive flag (status bit 7). If control bit 7 is set, it also raises irq_rx_done.
- R3: Reading offset 0 while control bit 4 is clear returns 0 and changes nothing. Otherwise the read returns the held byte ANDed with the size mask, or 0 if the buffer is empty. It also empties the buffer, clears status bit 7 and lowers irq_rx_done. bus_rdata is valid in the cycle after any read.
- R4: The size code is {control bit 2, format bit 2, format bit 1}. Codes 0 to 3 select 5 to 8 data bits, and code 7 selects 8 bits. A write that forms code 4, 5 or 6 leaves the previous mask in force.
- R5: A write to offset 0 is ignored while the transmit enable (control bit 3) is clear. Otherwise the block pulses tx_valid for one cycle with the byte on tx_data and sets status bits 6 (transmit done) and 5 (data empty). If control bit 6 is set, irq_tx_done rises and status bit 6 is cleared. If control bit 5 is set, irq_tx_empty rises.
- R6: A status write changes only bits 6, 1 and 0 (mask 0x43). Writing 1 to bit 6 clears it and lowers irq_tx_done.
- R7: A control write preserves bit 1. If the written receive enable is clear, the holding buffer is flushed. Each interrupt line becomes its enable bit (7, 6 or 5) ANDed with the matching status flag (7, 6 or 5).
- R8: Baud high keeps only its low 4 bits. Baud low and format store the whole byte.
- R9: While pwr_down is high the block is held in its reset state: reads return 0, writes are ignored, rx_ready is low and all interrupt lines are low.
- R10: Offsets 6 and 7 read as 0, and writes to them change nothing.
- R11: If a byte is accepted in the same cycle as a data read, the accept wins: the read returns 0 and the byte stays held. A control write that clears the receive enable in the same cycle as an offered byte discards that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down: holds reset and makes the bus inert |
| bus_sel | input | 1 | Bus access strobe, one byte per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding buffer can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| irq_rx_done | output | 1 | Receive-done interrupt level |
| irq_tx_done | output | 1 | Transmit-done interrupt level |
| irq_tx_empty | output | 1 | Transmit-data-empty interrupt level |

## Verification
Two functions can land in the same cycle: the arrival of a received byte and a CPU access to the data or control register. The bench provokes this by raising rx_valid at the same negative edge as it issues a data read into an empty buffer. The read must return 0, and a following read must return the new byte with the receive flag set. The bench also offers a byte in the same cycle as a control write that clears the receive enable. It then re-enables reception and requires an empty buffer and a clear receive flag.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  // register offsets
  localparam int OFF_DATA    = 0;
  localparam int OFF_STAT    = 1;
  localparam int OFF_CTRL    = 2;
  localparam int OFF_FMT     = 3;
  localparam int OFF_BAUD_LO = 4;
  localparam int OFF_BAUD_HI = 5;
  // status bits
  localparam int ST_RX_DONE  = 7;
  localparam int ST_TX_DONE  = 6;
  localparam int ST_TX_EMPTY = 5;
  // control bits
  localparam int CT_RX_IE    = 7;
  localparam int CT_TX_IE    = 6;
  localparam int CT_EMPTY_IE = 5;
  localparam int CT_RX_EN    = 4;
  localparam int CT_TX_EN    = 3;
  localparam int CT_SIZE_HI  = 2;
  // format bits
  localparam int FM_SIZE_MID = 2;
  localparam int FM_SIZE_LO  = 1;
endpackage

// File: rtl/sp_char_mask.sv
module sp_char_mask #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              update,
  input  logic [2:0]        code,
  output logic [DATA_W-1:0] mask
);
  int unsigned          sel_bits;
  logic                 code_ok;
  logic [DATA_W-1:0]    cand;

  always_comb begin
    code_ok  = 1'b1;
    sel_bits = DATA_W;
    if (!code[2]) sel_bits = MIN_BITS + int'(code[1:0]);
    else if (code != 3'b111) code_ok = 1'b0;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign cand[i] = (i < sel_bits);
  end

  always_ff @(posedge clk) begin
    if (clr) mask <= '1;
    else if (update && code_ok) mask <= cand;
  end
endmodule

// File: rtl/sp_rx_hold.sv
module sp_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              consume,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (clr) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (consume) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_regs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 3,
  parameter int BAUD_HI_W     = 4,
  parameter int MIN_CHAR_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq_rx_done,
  output logic              irq_tx_done,
  output logic              irq_tx_empty
);
  localparam logic [DATA_W-1:0] STAT_WMASK = DATA_W'(8'h43);
  localparam logic [DATA_W-1:0] CTRL_WMASK = DATA_W'(8'hFD);
  localparam logic [DATA_W-1:0] STAT_RST   = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] FMT_RST    = DATA_W'(8'h06);

  logic                 clr;
  logic                 acc, rd, wr;
  logic                 wr_data, rd_data, wr_stat, wr_ctrl, wr_fmt, wr_blo, wr_bhi;
  logic                 flush, rx_take;
  logic [DATA_W-1:0]    stat_q, stat_d, ctrl_q, fmt_q, baud_lo_q;
  logic [BAUD_HI_W-1:0] baud_hi_q;
  logic                 irq_rx_d, irq_tx_d, irq_em_d;
  logic                 hold_valid;
  logic [DATA_W-1:0]    hold_data, mask_q, rd_mux;
  logic [2:0]           size_code;

  assign clr     = rst | pwr_down;
  assign acc     = bus_sel & ~pwr_down;
  assign rd      = acc & ~bus_we;
  assign wr      = acc & bus_we;
  assign wr_data = wr & (int'(bus_addr) == OFF_DATA) & ctrl_q[CT_TX_EN];
  assign rd_data = rd & (int'(bus_addr) == OFF_DATA) & ctrl_q[CT_RX_EN];
  assign wr_stat = wr & (int'(bus_addr) == OFF_STAT);
  assign wr_ctrl = wr & (int'(bus_addr) == OFF_CTRL);
  assign wr_fmt  = wr & (int'(bus_addr) == OFF_FMT);
  assign wr_blo  = wr & (int'(bus_addr) == OFF_BAUD_LO);
  assign wr_bhi  = wr & (int'(bus_addr) == OFF_BAUD_HI);

  assign flush    = wr_ctrl & ~bus_wdata[CT_RX_EN];
  assign rx_ready = ctrl_q[CT_RX_EN] & ~hold_valid & ~pwr_down;
  assign rx_take  = rx_valid & rx_ready & ~flush;

  // size code built from whichever register is being written this cycle
  assign size_code = wr_ctrl ? {bus_wdata[CT_SIZE_HI], fmt_q[FM_SIZE_MID], fmt_q[FM_SIZE_LO]}
                             : {ctrl_q[CT_SIZE_HI], bus_wdata[FM_SIZE_MID], bus_wdata[FM_SIZE_LO]};

  sp_char_mask #(.DATA_W(DATA_W), .MIN_BITS(MIN_CHAR_BITS)) u_mask (
    .clk(clk), .clr(clr), .update(wr_ctrl | wr_fmt), .code(size_code), .mask(mask_q)
  );

  sp_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .clr(clr), .flush(flush), .load(rx_take), .load_data(rx_data),
    .consume(rd_data), .valid(hold_valid), .data(hold_data)
  );

  always_comb begin
    stat_d   = stat_q;
    irq_rx_d = irq_rx_done;
    irq_tx_d = irq_tx_done;
    irq_em_d = irq_tx_empty;
    if (wr_stat) begin
      stat_d = (bus_wdata & STAT_WMASK) | (stat_q & ~STAT_WMASK);
      if (bus_wdata[ST_TX_DONE]) begin
        stat_d[ST_TX_DONE] = 1'b0;
        irq_tx_d           = 1'b0;
      end
    end
    if (wr_data) begin
      stat_d[ST_TX_DONE]  = 1'b1;
      stat_d[ST_TX_EMPTY] = 1'b1;
      if (ctrl_q[CT_TX_IE]) begin
        irq_tx_d           = 1'b1;
        stat_d[ST_TX_DONE] = 1'b0;
      end
      if (ctrl_q[CT_EMPTY_IE]) irq_em_d = 1'b1;
    end
    if (rd_data) begin
      stat_d[ST_RX_DONE] = 1'b0;
      irq_rx_d           = 1'b0;
    end
    if (wr_ctrl) begin
      irq_rx_d = bus_wdata[CT_RX_IE]    & stat_q[ST_RX_DONE];
      irq_tx_d = bus_wdata[CT_TX_IE]    & stat_q[ST_TX_DONE];
      irq_em_d = bus_wdata[CT_EMPTY_IE] & stat_q[ST_TX_EMPTY];
    end
    if (rx_take) begin
      stat_d[ST_RX_DONE] = 1'b1;
      if (ctrl_q[CT_RX_IE]) irq_rx_d = 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      OFF_DATA:    if (ctrl_q[CT_RX_EN] && hold_valid) rd_mux = hold_data & mask_q;
      OFF_STAT:    rd_mux = stat_q;
      OFF_CTRL:    rd_mux = ctrl_q;
      OFF_FMT:     rd_mux = fmt_q;
      OFF_BAUD_LO: rd_mux = baud_lo_q;
      OFF_BAUD_HI: rd_mux = DATA_W'(baud_hi_q);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      stat_q       <= STAT_RST;
      ctrl_q       <= '0;
      fmt_q        <= FMT_RST;
      baud_lo_q    <= '0;
      baud_hi_q    <= '0;
      irq_rx_done  <= 1'b0;
      irq_tx_done  <= 1'b0;
      irq_tx_empty <= 1'b0;
      bus_rdata    <= '0;
      tx_valid     <= 1'b0;
      tx_data      <= '0;
    end else begin
      stat_q       <= stat_d;
      irq_rx_done  <= irq_rx_d;
      irq_tx_done  <= irq_tx_d;
      irq_tx_empty <= irq_em_d;
      if (wr_ctrl) ctrl_q    <= (bus_wdata & CTRL_WMASK) | (ctrl_q & ~CTRL_WMASK);
      if (wr_fmt)  fmt_q     <= bus_wdata;
      if (wr_blo)  baud_lo_q <= bus_wdata;
      if (wr_bhi)  baud_hi_q <= bus_wdata[BAUD_HI_W-1:0];
      bus_rdata <= rd ? rd_mux : '0;
      tx_valid  <= wr_data;
      if (wr_data) tx_data <= bus_wdata;
    end
  end
endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_down,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq_rx_done,
  input logic              irq_tx_done,
  input logic              irq_tx_empty,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] fmt_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              hold_valid
);
  logic ctrl_wr, fmt_wr, rx_off_wr, rsv_code;
  assign ctrl_wr   = !pwr_down && bus_sel && bus_we && bus_addr == ADDR_W'(2);
  assign fmt_wr    = !pwr_down && bus_sel && bus_we && bus_addr == ADDR_W'(3);
  assign rx_off_wr = ctrl_wr && !bus_wdata[4];
  assign rsv_code  = (ctrl_wr && bus_wdata[2] && !(fmt_q[2] && fmt_q[1])) ||
                     (fmt_wr && ctrl_q[2] && !(bus_wdata[2] && bus_wdata[1]));

  // R2: the receive interrupt never stands without its flag
  p_rx_irq_has_flag_r2: assert property (@(posedge clk) disable iff (rst)
    irq_rx_done |-> stat_q[7]);

  // R2: a completed handshake fills the buffer and flags it
  p_accept_fills_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !rx_off_wr) |=> (hold_valid && stat_q[7]));

  // R5: a transmit strobe follows an enabled data write
  p_tx_from_write_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_sel && bus_we && bus_addr == ADDR_W'(0) && ctrl_q[3] && !pwr_down));

  // R4: reserved size codes keep the mask
  p_reserved_keeps_mask_r4: assert property (@(posedge clk) disable iff (rst)
    rsv_code |=> $stable(mask_q));

  // R7: clearing the receive enable empties the buffer
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    rx_off_wr |=> !hold_valid);

  // R9: power-down leaves the outputs quiet
  p_pwr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (bus_rdata == '0 && !irq_rx_done && !irq_tx_done && !irq_tx_empty && !tx_valid));

  // R10: unmapped offsets read as zero
  p_hole_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr >= ADDR_W'(6)) |=> bus_rdata == '0);
endmodule

bind serial_port_regs serial_port_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_down(pwr_down), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .irq_rx_done(irq_rx_done), .irq_tx_done(irq_tx_done), .irq_tx_empty(irq_tx_empty),
  .stat_q(stat_q), .ctrl_q(ctrl_q), .fmt_q(fmt_q), .mask_q(mask_q), .hold_valid(hold_valid)
);

// File: tb/serial_port_regs_tb.sv
module serial_port_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_down = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq_rx_done, irq_tx_done, irq_tx_empty;

  int n_run = 0, n_fail = 0;
  logic       last_tx_v;
  logic [7:0] last_tx_d;
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_port_regs u_dut (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_rx_done(irq_rx_done),
    .irq_tx_done(irq_tx_done), .irq_tx_empty(irq_tx_empty)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    last_tx_v = tx_valid; last_tx_d = tx_data;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic push(input string tag, input logic [7:0] d, input logic exp_ok);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    chk(tag, {7'd0, rx_ready}, {7'd0, exp_ok});
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd(3'd1, v); chk("R1 status", v, 8'h20);
    rd(3'd2, v); chk("R1 control", v, 8'h00);
    rd(3'd3, v); chk("R1 format", v, 8'h06);
    rd(3'd4, v); chk("R1 baud lo", v, 8'h00);
    rd(3'd5, v); chk("R1 baud hi", v, 8'h00);
    chk("R1 irqs+ready", {4'd0, irq_rx_done, irq_tx_done, irq_tx_empty, rx_ready}, 8'h00);
  endtask

  task automatic t_rx();
    do_reset();
    wr(3'd2, 8'h90);
    push("R2 ready when empty", 8'h5A, 1'b1);
    chk("R2 irq raised", {7'd0, irq_rx_done}, 8'h01);
    chk("R2 ready low when full", {7'd0, rx_ready}, 8'h00);
    rd(3'd1, v); chk("R2 flag set", v, 8'hA0);
    push("R2 full refuses", 8'h11, 1'b0);
    rd(3'd0, v); chk("R3 data read", v, 8'h5A);
    chk("R3 irq dropped", {7'd0, irq_rx_done}, 8'h00);
    rd(3'd1, v); chk("R3 flag cleared", v, 8'h20);
    rd(3'd0, v); chk("R3 empty read", v, 8'h00);
  endtask

  task automatic t_flush();
    do_reset();
    wr(3'd2, 8'h90);
    push("R7 setup", 8'h33, 1'b1);
    wr(3'd2, 8'h80);
    chk("R7 irq recomputed on", {7'd0, irq_rx_done}, 8'h01);
    rd(3'd0, v); chk("R3 read while disabled", v, 8'h00);
    chk("R3 disabled read keeps irq", {7'd0, irq_rx_done}, 8'h01);
    wr(3'd2, 8'h10);
    chk("R7 irq recomputed off", {7'd0, irq_rx_done}, 8'h00);
    rd(3'd0, v); chk("R7 buffer flushed", v, 8'h00);
  endtask

  task automatic size_case(input string tag, input logic [7:0] c, input logic [7:0] f, input logic [7:0] exp);
    wr(3'd3, f); wr(3'd2, c);
    push(tag, 8'hFF, 1'b1);
    rd(3'd0, v); chk(tag, v, exp);
  endtask

  task automatic t_size();
    do_reset();
    size_case("R4 code0 5 bits", 8'h10, 8'h00, 8'h1F);
    size_case("R4 code1 6 bits", 8'h10, 8'h02, 8'h3F);
    size_case("R4 code2 7 bits", 8'h10, 8'h04, 8'h7F);
    size_case("R4 code3 8 bits", 8'h10, 8'h06, 8'hFF);
    size_case("R4 code7 8 bits", 8'h14, 8'h06, 8'hFF);
    size_case("R4 set 6 bits", 8'h10, 8'h02, 8'h3F);
    size_case("R4 reserved keeps", 8'h14, 8'h02, 8'h3F);
  endtask

  task automatic t_tx();
    do_reset();
    wr(3'd0, 8'h11);
    chk("R5 disabled no strobe", {7'd0, last_tx_v}, 8'h00);
    rd(3'd1, v); chk("R5 disabled no flags", v, 8'h20);
    wr(3'd2, 8'h08);
    wr(3'd0, 8'h22);
    chk("R5 strobe", {7'd0, last_tx_v}, 8'h01);
    chk("R5 byte", last_tx_d, 8'h22);
    @(negedge clk); chk("R5 one-cycle strobe", {7'd0, tx_valid}, 8'h00);
    rd(3'd1, v); chk("R5 flags set", v, 8'h60);
    wr(3'd2, 8'h68);
    chk("R7 irqs from flags", {6'd0, irq_tx_done, irq_tx_empty}, 8'h03);
    wr(3'd1, 8'h40);
    chk("R6 w1c drops irq", {6'd0, irq_tx_done, irq_tx_empty}, 8'h01);
    rd(3'd1, v); chk("R6 done cleared", v, 8'h20);
    wr(3'd0, 8'h33);
    chk("R5 irq raised", {7'd0, irq_tx_done}, 8'h01);
    rd(3'd1, v); chk("R5 done auto-cleared", v, 8'h20);
  endtask

  task automatic t_masks();
    do_reset();
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R6 status mask", v, 8'h23);
    wr(3'd1, 8'h00); rd(3'd1, v); chk("R6 status clear", v, 8'h20);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R7 bit1 preserved", v, 8'hFD);
    wr(3'd4, 8'hAB); rd(3'd4, v); chk("R8 baud lo", v, 8'hAB);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R8 baud hi", v, 8'h0F);
    wr(3'd3, 8'hC9); rd(3'd3, v); chk("R8 format full", v, 8'hC9);
    wr(3'd6, 8'h55); wr(3'd7, 8'h55);
    rd(3'd6, v); chk("R10 offset 6", v, 8'h00);
    rd(3'd7, v); chk("R10 offset 7", v, 8'h00);
    rd(3'd4, v); chk("R10 no side effect", v, 8'hAB);
  endtask

  task automatic t_pwr();
    do_reset();
    wr(3'd4, 8'h12); wr(3'd2, 8'h70);
    wr(3'd0, 8'h00);
    @(negedge clk); pwr_down = 1'b1;
    rd(3'd4, v); chk("R9 read zero", v, 8'h00);
    wr(3'd4, 8'h99);
    chk("R9 quiet", {5'd0, irq_tx_done, irq_tx_empty, rx_ready}, 8'h00);
    @(negedge clk); pwr_down = 1'b0;
    rd(3'd4, v); chk("R9 reset baud", v, 8'h00);
    rd(3'd2, v); chk("R9 reset control", v, 8'h00);
    rd(3'd1, v); chk("R9 reset status", v, 8'h20);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(3'd2, 8'h10);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hA5;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
    @(negedge clk); rx_valid = 1'b0; bus_sel = 1'b0;
    chk("R11 read returns zero", bus_rdata, 8'h00);
    rd(3'd1, v); chk("R11 flag kept", v, 8'hA0);
    rd(3'd0, v); chk("R11 byte kept", v, 8'hA5);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h77;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h00;
    @(negedge clk); rx_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    wr(3'd2, 8'h10);
    rd(3'd1, v); chk("R11 discarded no flag", v, 8'h20);
    chk("R11 buffer empty", {7'd0, rx_ready}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rx();
    t_flush();
    t_size();
    t_tx();
    t_masks();
    t_pwr();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule